// File: doc/BRIEF.md
# Clock Control Register Bank

This block holds the software-visible configuration words of a clock control unit: an operating-mode word, two post-divider words, two PLL control words (one for the processor PLL, one for the system PLL), three clock-gating words and a power-management word. It sits on a plain 32-bit word bus with a byte address inside a 4 KB window, a write strobe, a read strobe, write data and registered read data. Every stored word has its own reset value and its own write mask. The mode word also carries one bit that every write sets.

Whenever software changes a word that affects output frequencies, the bank emits a single-cycle recompute pulse. A frequency engine further down the chip uses this pulse to re-derive its clock rates. The same pulse is issued once after reset is released, so that the engine starts from the reset configuration. The gating words are plain storage and never request a recompute. One address reads as a fixed identification-style constant, and the power-management word is read-only.

Top module: `clkctl_regbank`

## Requirements
- R1: The word index is the byte address shifted right by two, so address bits 1:0 are ignored. The map is: index 0 mode, 1 post-divider A, 2 post-divider B, 4 processor PLL, 6 system PLL, 8/9/10 gating words 0/1/2, 18 constant, 23 power-management. Every other index is unmapped.
- R2: After reset, reads return mode 0x074b0b7b, post-divider A 0xff870b48, post-divider B 0x49fcfe7f, processor PLL 0x04001800, system PLL 0x04043001, all gating words 0xffffffff and power-management 0x80209828. While reset is held, read data and the recompute pulse are 0.
- R3: A write to the mode word stores the write data ANDed with 0x3b6fdfff, with bit 26 then set to 1.
- R4: A write to post-divider A stores the data ANDed with 0xff9f3fff. A write to post-divider B stores all 32 bits.
- R5: A write to either PLL word stores the data ANDed with 0xbfff3fff.
- R6: Writes to the gating words store all 32 bits.
- R7: A read of index 18 returns 0x00004040. A read of an unmapped index returns 0.
- R8: Writes to the power-management word, to index 18 and to unmapped indices change no readable value.
- R9: Read data is registered: it shows the addressed word one cycle after a read strobe, and holds its value in cycles that follow no read strobe. A read and a write in the same cycle return the value from before the write.
- R10: In the cycle after a write to the mode, post-divider or PLL words, the recompute pulse is high for one cycle per write. Writes to any other index leave the pulse low.
- R11: The recompute pulse is high for exactly one cycle, one cycle after the first clock edge at which reset is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address within the window |
| bus_wr | input | 1 | Write strobe, accepted at the rising edge |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| recalc_pulse | output | 1 | One-cycle request to recompute frequencies |

## Verification
Each stored word is written with all ones, all zeros and two alternating checkerboards. All-ones exposes every kept bit of a mask, and all-zeros shows that the mode word's forced bit survives. The checkerboards show that no bit is crossed or tied. Reads sweep the mapped indices, the constant and a spread of unmapped indices, including addresses with nonzero low bits, so that decode aliasing and index mistakes show up. A long mixed sequence of random reads and writes over the whole map, with back-to-back frequency writes and read-during-write cycles, separates a correct pulse and a correct read timing from pulses that merge, pulses that go missing and reads that return the newly written value.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

    localparam int DATA_W     = 32;
    localparam int WIN_ADDR_W = 12;
    localparam int IDX_W      = WIN_ADDR_W - 2;

    // slot numbering: stored words first, then read-only sources
    localparam int SL_MODE  = 0;
    localparam int SL_DIVA  = 1;
    localparam int SL_DIVB  = 2;
    localparam int SL_MPLL  = 3;
    localparam int SL_SPLL  = 4;
    localparam int SL_GATE0 = 5;
    localparam int SL_GATE1 = 6;
    localparam int SL_GATE2 = 7;
    localparam int SL_PWR   = 8;
    localparam int SL_CONST = 9;
    localparam int NSTORE   = 8;
    localparam int NSLOT    = 10;

    typedef logic [DATA_W-1:0] word_t;

    localparam word_t CONST_VALUE = 32'h0000_4040;
    localparam word_t PWR_VALUE   = 32'h8020_9828;

    typedef struct packed {
        logic             wr;
        logic             rd;
        logic [IDX_W-1:0] idx;
        word_t            wdata;
    } bus_req_t;

    function automatic word_t pll_word(int pd, int mfd, int mfi, int mfn);
        word_t w;
        w = '0;
        w[29:26] = 4'(pd);
        w[25:16] = 10'(mfd);
        w[13:10] = 4'(mfi);
        w[9:0]   = 10'(mfn);
        return w;
    endfunction

    function automatic int slot_index(int s);
        case (s)
            SL_MODE:  return 0;
            SL_DIVA:  return 1;
            SL_DIVB:  return 2;
            SL_MPLL:  return 4;
            SL_SPLL:  return 6;
            SL_GATE0: return 8;
            SL_GATE1: return 9;
            SL_GATE2: return 10;
            SL_PWR:   return 23;
            default:  return 18;
        endcase
    endfunction

    function automatic word_t slot_mask(int s);
        case (s)
            SL_MODE:          return 32'h3b6f_dfff;
            SL_DIVA:          return 32'hff9f_3fff;
            SL_MPLL, SL_SPLL: return 32'hbfff_3fff;
            default:          return '1;
        endcase
    endfunction

    function automatic word_t slot_force(int s);
        return (s == SL_MODE) ? 32'h0400_0000 : '0;
    endfunction

    function automatic word_t slot_reset(int s);
        case (s)
            SL_MODE: return 32'h074b_0b7b;
            SL_DIVA: return 32'hff87_0b48;
            SL_DIVB: return 32'h49fc_fe7f;
            SL_MPLL: return pll_word(1, 0, 6, 0);
            SL_SPLL: return pll_word(1, 4, 12, 1);
            default: return '1;
        endcase
    endfunction

    function automatic logic slot_recalc(int s);
        return (s <= SL_SPLL);
    endfunction

endpackage

// File: rtl/clkctl_decode.sv
module clkctl_decode
    import clkctl_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    output logic [NSLOT-1:0] hit,
    output logic             freq_hit,
    output logic             gate_hit
);
    logic [NSLOT-1:0] recalc_vec;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        assign hit[s]        = (idx == IDX_W'(slot_index(s)));
        assign recalc_vec[s] = hit[s] & slot_recalc(s);
    end

    assign freq_hit = |recalc_vec;
    assign gate_hit = hit[SL_GATE0] | hit[SL_GATE1] | hit[SL_GATE2];
endmodule

// File: rtl/clkctl_field.sv
module clkctl_field
    import clkctl_pkg::*;
#(
    parameter word_t RST_VAL = '0,
    parameter word_t WR_MASK = '1,
    parameter word_t SET_VAL = '0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  word_t wdata,
    output word_t q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= RST_VAL;
        else if (we) q <= (wdata & WR_MASK) | SET_VAL;
    end
endmodule

// File: rtl/clkctl_rdmux.sv
module clkctl_rdmux
    import clkctl_pkg::*;
(
    input  logic [NSLOT-1:0]              hit,
    input  logic [NSTORE-1:0][DATA_W-1:0] store,
    output word_t                         rd_word
);
    always_comb begin
        rd_word = '0;
        for (int s = 0; s < NSTORE; s++) begin
            if (hit[s]) rd_word = rd_word | store[s];
        end
        if (hit[SL_PWR])   rd_word = rd_word | PWR_VALUE;
        if (hit[SL_CONST]) rd_word = rd_word | CONST_VALUE;
    end
endmodule

// File: rtl/clkctl_regbank.sv
module clkctl_regbank
    import clkctl_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [WIN_ADDR_W-1:0] bus_addr,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic                  recalc_pulse
);
    bus_req_t                    req;
    logic [NSLOT-1:0]            hit;
    logic                        freq_hit;
    logic                        gate_hit;
    logic [NSTORE-1:0][DATA_W-1:0] store;
    word_t                       rd_word;
    logic                        boot_q;
    logic                        addr_unused;

    assign req.wr      = bus_wr;
    assign req.rd      = bus_rd;
    assign req.idx     = bus_addr[WIN_ADDR_W-1:2];
    assign req.wdata   = bus_wdata;
    assign addr_unused = ^bus_addr[1:0];

    clkctl_decode u_dec (
        .idx      (req.idx),
        .hit      (hit),
        .freq_hit (freq_hit),
        .gate_hit (gate_hit)
    );

    for (genvar g = 0; g < NSTORE; g++) begin : g_word
        clkctl_field #(
            .RST_VAL (slot_reset(g)),
            .WR_MASK (slot_mask(g)),
            .SET_VAL (slot_force(g))
        ) u_word (
            .clk   (clk),
            .rst   (rst),
            .we    (req.wr & hit[g]),
            .wdata (req.wdata),
            .q     (store[g])
        );
    end

    clkctl_rdmux u_mux (
        .hit     (hit),
        .store   (store),
        .rd_word (rd_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata    <= '0;
            recalc_pulse <= 1'b0;
            boot_q       <= 1'b1;
        end else begin
            if (req.rd) bus_rdata <= rd_word;
            recalc_pulse <= boot_q | (req.wr & freq_hit);
            boot_q       <= 1'b0;
        end
    end

    // R1: at most one slot decodes any index
    p_onehot_decode_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit));

    // R3: the forced mode bit is set after every mode write
    p_mode_force_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && hit[SL_MODE]) |=> store[SL_MODE][26]);

    // R7: constant index and unmapped reads
    p_const_read_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && hit[SL_CONST]) |=> (bus_rdata == CONST_VALUE));
    p_unmapped_read_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && (hit == '0)) |=> (bus_rdata == '0));

    // R9: read data holds without a strobe
    p_rdata_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));

    // R10: pulse follows frequency writes, never gating writes
    p_recalc_write_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && freq_hit) |=> recalc_pulse);
    p_no_recalc_gate_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && gate_hit && !boot_q) |=> !recalc_pulse);

    // R11: one pulse after reset release
    p_boot_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        boot_q |=> recalc_pulse);
endmodule

// File: tb/clkctl_regbank_test.sv
module clkctl_regbank_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        recalc_pulse;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [31:0] mreg [int];
    logic [31:0] exp_rdata;
    bit          exp_recalc;
    bit          boot_m;

    always #4 clk = ~clk;

    clkctl_regbank uut (
        .clk          (clk),
        .rst          (rst),
        .bus_addr     (bus_addr),
        .bus_wr       (bus_wr),
        .bus_rd       (bus_rd),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .recalc_pulse (recalc_pulse)
    );

    function automatic void model_reset();
        mreg.delete();
        mreg[0]  = 32'h074b0b7b;
        mreg[1]  = 32'hff870b48;
        mreg[2]  = 32'h49fcfe7f;
        mreg[4]  = 32'h04001800;
        mreg[6]  = 32'h04043001;
        mreg[8]  = 32'hffffffff;
        mreg[9]  = 32'hffffffff;
        mreg[10] = 32'hffffffff;
    endfunction

    function automatic logic [31:0] model_read(int idx);
        if (idx == 18) return 32'h00004040;
        if (idx == 23) return 32'h80209828;
        if (mreg.exists(idx)) return mreg[idx];
        return 32'h0;
    endfunction

    function automatic void model_write(int idx, logic [31:0] d);
        case (idx)
            0:       mreg[0] = (d & 32'h3b6fdfff) | 32'h04000000;
            1:       mreg[1] = d & 32'hff9f3fff;
            2:       mreg[2] = d;
            4, 6:    mreg[idx] = d & 32'hbfff3fff;
            8, 9, 10: mreg[idx] = d;
            default: ;
        endcase
    endfunction

    task automatic compare(string rtag, string ptag);
        checks++;
        if (bus_rdata !== exp_rdata) begin
            fails++;
            $display("FAIL %s rdata actual=%h expected=%h", rtag, bus_rdata, exp_rdata);
        end
        checks++;
        if (recalc_pulse !== exp_recalc) begin
            fails++;
            $display("FAIL %s recalc actual=%b expected=%b", ptag, recalc_pulse, exp_recalc);
        end
    endtask

    // one bus cycle, driven at the falling edge, checked at the next one
    task automatic step(bit wr, bit rd, logic [11:0] addr, logic [31:0] d, string rtag);
        int idx;
        bit was_boot;
        bus_wr = wr; bus_rd = rd; bus_addr = addr; bus_wdata = d;
        @(posedge clk);
        idx = int'(addr >> 2);
        if (rd) exp_rdata = model_read(idx);
        was_boot = boot_m;
        exp_recalc = boot_m || (wr && (idx == 0 || idx == 1 || idx == 2 || idx == 4 || idx == 6));
        boot_m = 0;
        if (wr) model_write(idx, d);
        @(negedge clk);
        compare(rtag, was_boot ? "R11" : "R10");
    endtask

    task automatic rd(int idx, string rtag);
        step(0, 1, 12'(idx << 2), 32'h0, rtag);
    endtask

    task automatic wr(int idx, logic [31:0] d, string rtag);
        step(1, 0, 12'(idx << 2), d, rtag);
    endtask

    initial begin
        int mapped [8] = '{0, 1, 2, 4, 6, 8, 9, 10};
        int pool [14]  = '{0, 1, 2, 4, 6, 8, 9, 10, 18, 23, 3, 5, 7, 200};
        logic [31:0] pats [4] = '{32'hffffffff, 32'h00000000, 32'ha5a5a5a5, 32'h5a5a5a5a};
        model_reset();
        boot_m = 1;
        exp_rdata = '0;
        exp_recalc = 0;
        bus_rd = 1;
        repeat (3) begin
            @(posedge clk);
            @(negedge clk);
            compare("R2", "R2");
        end
        rst = 0;
        // R11: pulse in the first cycle after release
        step(0, 0, 12'h0, 32'h0, "R11");
        step(0, 0, 12'h0, 32'h0, "R11");
        // R2: reset values
        foreach (mapped[i]) rd(mapped[i], "R2");
        rd(23, "R2");
        // R7: constant and unmapped
        rd(18, "R7");
        foreach (pool[i]) if (pool[i] >= 18) rd(pool[i], "R7");
        rd(3, "R7"); rd(5, "R7"); rd(11, "R7"); rd(1023, "R7");
        // R1: low address bits ignored
        step(0, 1, 12'h005, 32'h0, "R1");
        step(0, 1, 12'h01b, 32'h0, "R1");
        step(1, 0, 12'h007, 32'h12345678, "R1");
        rd(1, "R1");
        // R3..R6: masks under four patterns
        foreach (pats[p]) begin
            foreach (mapped[i]) wr(mapped[i], pats[p], "R10");
            rd(0, "R3"); rd(1, "R4"); rd(2, "R4");
            rd(4, "R5"); rd(6, "R5");
            rd(8, "R6"); rd(9, "R6"); rd(10, "R6");
        end
        // R8: writes with no visible effect
        wr(23, 32'h0, "R8");  rd(23, "R8");
        wr(18, 32'hffffffff, "R8"); rd(18, "R8");
        wr(3, 32'hdeadbeef, "R8"); rd(3, "R8");
        wr(200, 32'hdeadbeef, "R8");
        foreach (mapped[i]) rd(mapped[i], "R8");
        // R10: back-to-back frequency writes give back-to-back pulses
        wr(0, 32'h1, "R10"); wr(4, 32'h2, "R10"); wr(8, 32'h3, "R10");
        // R9: read during write returns old value; hold with no strobe
        step(1, 1, 12'h004, 32'h0000abcd, "R9");
        step(0, 0, 12'h000, 32'h0, "R9");
        step(0, 0, 12'h008, 32'h0, "R9");
        rd(1, "R9");
        // mixed traffic
        for (int n = 0; n < 400; n++) begin
            int k;
            k = int'($urandom_range(0, 13));
            step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 12'(pool[k] << 2) | 12'($urandom_range(0, 3)), $urandom, "R9");
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule